// File: doc/BRIEF.md
# Program Counter and Return Stack

This block sequences instruction fetch for a small microcontroller whose instructions are 12 bits wide. It keeps a 10-bit fetch address over a 1024-word space and a two-level hardware return stack. Each cycle, the instruction decoder outside the block presents the flow class of the instruction now executing. That instruction is the one fetched in the previous cycle. The decoder also presents the instruction's address field, a data byte for writes to the low address byte, and the page-select bit. The block returns the address to fetch next and a one-cycle flush request whenever the flow changes.

Fetch and execute overlap by one cycle. On a taken change of flow, the word fetched in the cycle after the change belongs to the old path. The block raises its flush output for that cycle and ignores any flow class presented while the flush is high, so the discarded slot has no effect. Calls and low-byte writes can reach only the lower half of a 512-word page, because address bit 8 is cleared for them. The stack gives no sign when it overflows or underflows.

All pins are plain control and status pins, with no valid/ready handshake. The fetch address is valid in every cycle, and the block accepts one flow class per cycle without back-pressure. The flush output tells the decoder that the flow class it presents in that cycle is disregarded.

Top module: `pcseq_top`

## Requirements
- R1: While reset is held, and right after it is released, the fetch address is 3FFh and the flush output is low. The first sequential step after reset gives 000h. Both stack levels reset to 000h.
- R2: The flow class codes are 0 sequential, 1 jump, 2 call, 3 return and 4 low-byte write. Codes 5 to 7 behave as sequential. A sequential step adds one to the fetch address modulo 1024, so 3FFh is followed by 000h.
- R3: A jump loads address bits 8:0 from the address field and bit 9 from the page-select bit.
- R4: A call or a low-byte write loads bits 7:0 from the field (call) or from the data byte (write), forces bit 8 to 0 and takes bit 9 from the page-select bit.
- R5: A call copies stack level 1 into level 2 and then pushes the current fetch address into level 1. The current fetch address is the call's own address plus one.
- R6: A return loads the fetch address from level 1 and copies level 2 into level 1, leaving level 2 as it was. Further returns therefore keep producing the old level-2 address.
- R7: After three nested calls only the two most recent return addresses remain, and no overflow indication exists.
- R8: The flush output is high for exactly the one cycle that follows a jump, call, return or low-byte write, and is never high in two consecutive cycles.
- R9: A flow class presented while flush is high is ignored. The fetch address simply advances by one and the stack is untouched.
- R10: The low-byte read port always equals bits 7:0 of the fetch address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Flow class of the executing instruction |
| addr_i | input | 9 | Address field of the executing instruction |
| data_i | input | 8 | Data byte for a low-byte write |
| page_i | input | 1 | Page-select bit |
| fetch_addr_o | output | 10 | Address to fetch this cycle |
| flush_o | output | 1 | The word fetched last cycle must be discarded |
| pcl_o | output | 8 | Low byte of the fetch address, for reads |

## Verification
Two of the block's functions can fall in the same cycle. A discarded slot can carry a new change of flow, which must be ignored while the address keeps advancing by one. The bench provokes this by placing a jump, call, return or low-byte write right after a taken change of flow. It also provokes it through a program-memory walk in which opcodes come from whatever word was fetched, including the discarded ones. It judges the outcome from the fetch address, the flush output and the stack contents that a later return brings out.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  typedef enum logic [2:0] {
    OP_SEQ  = 3'd0,
    OP_JMP  = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_PCLW = 3'd4
  } flow_op_e;

  // unused codes fall back to a plain sequential step
  function automatic flow_op_e decode_op(input logic [2:0] raw);
    case (raw)
      3'd1:    return OP_JMP;
      3'd2:    return OP_CALL;
      3'd3:    return OP_RET;
      3'd4:    return OP_PCLW;
      default: return OP_SEQ;
    endcase
  endfunction

endpackage

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
  parameter int W     = 10,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_val,
  output logic [W-1:0] top_o
);

  logic [W-1:0] lvl [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
    logic [W-1:0] from_above;
    logic [W-1:0] from_below;

    if (i == 0) begin : g_first
      assign from_above = push_val;
    end else begin : g_rest
      assign from_above = lvl[i-1];
    end

    // the deepest level keeps its value on a pop
    if (i == DEPTH - 1) begin : g_last
      assign from_below = lvl[i];
    end else begin : g_inner
      assign from_below = lvl[i+1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)    lvl[i] <= '0;
      else if (push) lvl[i] <= from_above;
      else if (pop)  lvl[i] <= from_below;
    end
  end

  assign top_o = lvl[0];

endmodule

// File: rtl/pcseq_next.sv
module pcseq_next
  import pcseq_pkg::*;
#(
  parameter int LOW_W = 8,
  localparam int PC_W = LOW_W + 2
) (
  input  flow_op_e          op,
  input  logic [PC_W-1:0]   pc_q,
  input  logic              page,
  input  logic [LOW_W:0]    addr_field,
  input  logic [LOW_W-1:0]  data,
  input  logic [PC_W-1:0]   stack_top,
  output logic [PC_W-1:0]   nxt,
  output logic              redirect
);

  always_comb begin
    redirect = 1'b1;
    case (op)
      OP_JMP:  nxt = {page, addr_field};
      OP_CALL: nxt = {page, 1'b0, addr_field[LOW_W-1:0]};
      OP_PCLW: nxt = {page, 1'b0, data};
      OP_RET:  nxt = stack_top;
      default: begin
        nxt      = pc_q + 1'b1;
        redirect = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
  import pcseq_pkg::*;
#(
  parameter int LOW_W = 8,
  parameter int DEPTH = 2,
  localparam int PC_W = LOW_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op_i,
  input  logic [LOW_W:0]   addr_i,
  input  logic [LOW_W-1:0] data_i,
  input  logic             page_i,
  output logic [PC_W-1:0]  fetch_addr_o,
  output logic             flush_o,
  output logic [LOW_W-1:0] pcl_o
);

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_nxt;
  logic [PC_W-1:0] stack_top;
  logic            flush_q;
  logic            redirect;
  flow_op_e        eff_op;

  // the slot after a change of flow holds a stale word: execute nothing
  assign eff_op = flush_q ? OP_SEQ : decode_op(op_i);

  pcseq_next #(.LOW_W(LOW_W)) u_next (
    .op         (eff_op),
    .pc_q       (pc_q),
    .page       (page_i),
    .addr_field (addr_i),
    .data       (data_i),
    .stack_top  (stack_top),
    .nxt        (pc_nxt),
    .redirect   (redirect)
  );

  // pc_q already points one past the executing call
  pcseq_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (eff_op == OP_CALL),
    .pop      (eff_op == OP_RET),
    .push_val (pc_q),
    .top_o    (stack_top)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q    <= '1;
      flush_q <= 1'b0;
    end else begin
      pc_q    <= pc_nxt;
      flush_q <= redirect;
    end
  end

  assign fetch_addr_o = pc_q;
  assign flush_o      = flush_q;
  assign pcl_o        = pc_q[LOW_W-1:0];

endmodule

// File: rtl/pcseq_chk.sv
module pcseq_chk #(
  parameter int LOW_W = 8,
  localparam int PC_W = LOW_W + 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       op_i,
  input logic [LOW_W:0]   addr_i,
  input logic             page_i,
  input logic [PC_W-1:0]  fetch_addr_o,
  input logic             flush_o
);

  logic [PC_W-1:0] fetch_inc;
  logic            is_change;
  assign fetch_inc = fetch_addr_o + 1'b1;
  assign is_change = (op_i >= 3'd1) && (op_i <= 3'd4);

  a_r8_flush_single: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> !flush_o);

  a_r8_flush_after_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_o && is_change) |=> flush_o);

  a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_o && !is_change) |=> (fetch_addr_o == $past(fetch_inc)));

  a_r9_slot_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> (fetch_addr_o == $past(fetch_inc)));

  a_r3_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_o && op_i == 3'd1) |=> (fetch_addr_o == $past({page_i, addr_i})));

  a_r4_lower_half: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_o && (op_i == 3'd2 || op_i == 3'd4))
      |=> (fetch_addr_o[LOW_W] == 1'b0 && fetch_addr_o[PC_W-1] == $past(page_i)));

endmodule

bind pcseq_top pcseq_chk #(.LOW_W(LOW_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_i         (op_i),
  .addr_i       (addr_i),
  .page_i       (page_i),
  .fetch_addr_o (fetch_addr_o),
  .flush_o      (flush_o)
);

// File: tb/tb_pcseq_top.sv
module tb_pcseq_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] op_i = 3'd0;
  logic [8:0] addr_i = '0;
  logic [7:0] data_i = '0;
  logic       page_i = 1'b0;
  logic [9:0] fetch_addr_o;
  logic       flush_o;
  logic [7:0] pcl_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state, built from the requirements
  logic [9:0] m_pc = 10'h3FF;
  logic [9:0] m_s0 = '0;
  logic [9:0] m_s1 = '0;
  logic       m_fl = 1'b0;

  pcseq_top dut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .addr_i(addr_i), .data_i(data_i),
    .page_i(page_i), .fetch_addr_o(fetch_addr_o), .flush_o(flush_o), .pcl_o(pcl_o)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " fetch"}, fetch_addr_o, m_pc);
    chk({tag, " flush R8"}, flush_o, m_fl);
    chk({tag, " pcl R10"}, pcl_o, m_pc[7:0]);
  endtask

  task automatic model(input logic [2:0] op, input logic [8:0] a, input logic [7:0] d,
                       input logic pg);
    if (m_fl) begin
      m_pc = m_pc + 10'd1;  // R9: slot ignored
      m_fl = 1'b0;
    end else begin
      m_fl = 1'b1;
      case (op)
        3'd1: m_pc = {pg, a};
        3'd2: begin m_s1 = m_s0; m_s0 = m_pc; m_pc = {pg, 1'b0, a[7:0]}; end
        3'd3: begin m_pc = m_s0; m_s0 = m_s1; end
        3'd4: m_pc = {pg, 1'b0, d};
        default: begin m_pc = m_pc + 10'd1; m_fl = 1'b0; end
      endcase
    end
  endtask

  // drive right after a falling edge, check at the next falling edge
  task automatic cyc(input logic [2:0] op, input logic [8:0] a, input logic [7:0] d,
                     input logic pg, input string tag);
    op_i = op; addr_i = a; data_i = d; page_i = pg;
    model(op, a, d, pg);
    @(negedge clk);
    check_all(tag);
  endtask

  function automatic logic [11:0] prog(input logic [9:0] ad);
    logic [15:0] h;
    h = 16'(ad) * 16'd40503 + 16'd7919;
    return h[15:4] ^ {2'b0, ad};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    check_all("R1 after release");
    cyc(3'd0, 9'd0, 8'd0, 1'b0, "R1 rollover");
    chk("R1 rollover value", fetch_addr_o, 0);

    // R2: sequential run over the whole space, including codes 5..7
    for (int i = 0; i < 1030; i++)
      cyc((i % 4 == 1) ? 3'(5 + i % 3) : 3'd0, 9'(i), 8'(i), 1'(i), "R2 seq");

    // R3: every jump target on both pages, then an idle slot
    for (int pg = 0; pg < 2; pg++)
      for (int a = 0; a < 512; a++) begin
        cyc(3'd1, 9'(a), 8'hA5, 1'(pg), "R3 jump");
        cyc(3'd0, 9'd0, 8'd0, 1'b0, "R8 slot");
      end

    // R4: every low-byte write on both pages, with noise in the address field
    for (int pg = 0; pg < 2; pg++)
      for (int d = 0; d < 256; d++) begin
        cyc(3'd4, 9'h1FF, 8'(d), 1'(pg), "R4 lowwrite");
        cyc(3'd0, 9'd0, 8'd0, 1'b0, "R8 slot");
      end

    // R5/R6: call every low target with bit 8 set in the field, then return
    for (int pg = 0; pg < 2; pg++)
      for (int d = 0; d < 256; d++) begin
        cyc(3'd0, 9'd0, 8'd0, 1'b0, "R2 pre");
        cyc(3'd2, 9'h100 | 9'(d), 8'd0, 1'(pg), "R4 R5 call");
        cyc(3'd0, 9'd0, 8'd0, 1'b0, "R8 slot");
        cyc(3'd0, 9'd0, 8'd0, 1'b0, "R2 body");
        cyc(3'd3, 9'd0, 8'd0, 1'b0, "R6 return");
        cyc(3'd0, 9'd0, 8'd0, 1'b0, "R8 slot");
      end

    // R7: three nested calls, then four returns
    cyc(3'd1, 9'h010, 8'd0, 1'b0, "R7 setup");
    cyc(3'd0, 9'd0, 8'd0, 1'b0, "R7 slot");
    for (int k = 0; k < 3; k++) begin
      cyc(3'd2, 9'(8'h40 + 8'(k * 16)), 8'd0, 1'(k), "R7 call");
      cyc(3'd0, 9'd0, 8'd0, 1'b0, "R7 slot");
    end
    for (int k = 0; k < 4; k++) begin
      cyc(3'd3, 9'd0, 8'd0, 1'b0, "R6 R7 return");
      cyc(3'd0, 9'd0, 8'd0, 1'b0, "R7 slot");
    end

    // R9: each change of flow placed in a discarded slot
    for (int k = 1; k <= 4; k++) begin
      cyc(3'd2, 9'h033, 8'd0, 1'b0, "R9 arm call");
      cyc(3'(k), 9'h1EE, 8'h77, 1'b1, "R9 ignored op");
      cyc(3'd3, 9'd0, 8'd0, 1'b0, "R9 stack intact");
      cyc(3'd0, 9'd0, 8'd0, 1'b0, "R9 slot");
    end

    // program-memory walk: opcodes come from the fetched word, flushed ones included
    begin
      logic [11:0] ir;
      logic [11:0] nxt;
      ir = 12'd0;
      for (int i = 0; i < 6000; i++) begin
        nxt = prog(fetch_addr_o);
        cyc(ir[11:9], ir[8:0], ir[7:0], ir[0] ^ ir[5], "R9 walk");
        ir = nxt;
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule